// File: doc/BRIEF.md
# Arithmetic Coder Update Fuser

This block sits in an MQ-style arithmetic coder. It lies between the stage that computes interval updates and the stage that turns the code register into bytes. Every incoming update is a pair made of an addend and a left shift. The addend goes into the code register first, and the shift follows. The fuser keeps one pending update. When the next update arrives, it tries to fold the two into a single equivalent update. The result reaches the output stage at a lower update rate.

Updates that leave the fuser wait in a parameterised FIFO. When the output stage stalls to emit more than one byte, the queue soaks up those cycles, so upstream does not see the stall. An end-of-block flag travels with the final update of a block. The flag forces the pending update out, so the last updates of a block are never lost.

Top module: `cm_update_fuser`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0, and no update is pending.
- R2: Shift merge. An update is pending with shift S1. An incoming update has addend 0, shift S2, and S1+S2 <= 15. The two become one pending update: its addend is the pending addend and its shift is S1+S2.
- R3: Addend merge. This rule applies only when R2 does not. The pending update has shift 0 and addend A1. The incoming update has addend A2, shift S2, and A1+A2 < 65536. The two become one pending update with addend A1+A2 and shift S2.
- R4: When neither R2 nor R3 applies, the pending update is queued unchanged. The incoming update becomes the new pending update.
- R5: Accepting a beat with `in_last`=1 marks the pending result as the end of its block. `in_ready` then stays 0 until that update has entered the queue. The update leaves with `out_last`=1, and nothing stays pending.
- R6: Every output update has a shift of at most 15.
- R7: The queue holds up to DEPTH updates. `in_ready` is 0 whenever the queue is full.
- R8: Updates leave in order. Apply the accepted input stream and the output stream to a 28-bit code register, and track the carries out of bit 27 as well. Both streams give the same register value and the same carries at each end of block.
- R9: `in_ready` depends only on internal state and never on `in_valid`. While `out_valid` is 1 and `out_ready` is 0, the output fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming update present |
| in_ready | output | 1 | Fuser accepts an update this cycle |
| in_add | input | AW (16) | Addend of the incoming update |
| in_sft | input | SW (4) | Left shift of the incoming update |
| in_last | input | 1 | Incoming update closes a block |
| out_valid | output | 1 | Head of queue holds an update |
| out_ready | input | 1 | Output stage takes the head update |
| out_add | output | AW (16) | Addend of the output update |
| out_sft | output | SW (4) | Left shift of the output update |
| out_last | output | 1 | Output update closes a block |

## Verification
Each output is checked in the cycle in which it is due:
- `in_ready` and `out_valid` are registered functions of state, so they are due in the cycle right after the clock edge that changed that state.
- A merged result stays pending with no fixed delay. It reaches the queue on the edge that accepts a non-mergeable update, or on the first edge with free space after an end-of-block beat. It becomes visible at the output one cycle later, once it reaches the queue head.

The bench keeps to this timing with a reference model that it steps once per clock. It compares ports just after the falling edge, before the next rising edge, so every expected value already includes the register stages in between. It also recomputes the code register from both streams at every block end.

// File: rtl/cmf_pkg.sv
package cmf_pkg;

   // Which merge rule the fuser applied to a pending/incoming pair.
   typedef enum logic [1:0] {
      FUSE_NONE  = 2'd0,
      FUSE_SHIFT = 2'd1,
      FUSE_ADD   = 2'd2,
      FUSE_BOTH  = 2'd3
   } fuse_kind_e;

   localparam int CMF_DEF_ADD_W     = 16;
   localparam int CMF_DEF_SFT_W     = 4;
   localparam int CMF_DEF_MAX_SHIFT = 15;
   localparam int CMF_DEF_DEPTH     = 16;

endpackage

// File: rtl/cmf_merge_rule.sv
module cmf_merge_rule
   import cmf_pkg::*;
#(
   parameter int AW          = CMF_DEF_ADD_W,
   parameter int SW          = CMF_DEF_SFT_W,
   parameter int MAX_SHIFT   = CMF_DEF_MAX_SHIFT,
   parameter bit ADD_MERGE   = 1'b1,
   parameter bit SHIFT_MERGE = 1'b1
)(
   input  logic [AW-1:0] held_add,
   input  logic [SW-1:0] held_sft,
   input  logic [AW-1:0] new_add,
   input  logic [SW-1:0] new_sft,
   output logic          can_merge,
   output logic [AW-1:0] m_add,
   output logic [SW-1:0] m_sft
);

   localparam logic [SW:0] SFT_LIMIT = (SW+1)'(MAX_SHIFT);

   logic [SW:0] sft_sum;
   logic [AW:0] add_sum;
   logic        shift_ok;
   logic        add_ok;
   fuse_kind_e  kind;

   assign sft_sum = {1'b0, held_sft} + {1'b0, new_sft};
   assign add_sum = {1'b0, held_add} + {1'b0, new_add};

   generate
      if (SHIFT_MERGE) begin : g_shift_on
         // second addend must vanish so the first shift can absorb the second
         assign shift_ok = (new_add == '0) && (sft_sum <= SFT_LIMIT);
      end else begin : g_shift_off
         assign shift_ok = 1'b0;
      end
      if (ADD_MERGE) begin : g_add_on
         // first shift must be zero so both addends hit the same bit weight
         assign add_ok = (held_sft == '0) && !add_sum[AW];
      end else begin : g_add_off
         assign add_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case ({add_ok, shift_ok})
         2'b11:   kind = FUSE_BOTH;
         2'b01:   kind = FUSE_SHIFT;
         2'b10:   kind = FUSE_ADD;
         default: kind = FUSE_NONE;
      endcase
   end

   always_comb begin
      can_merge = 1'b1;
      m_add     = held_add;
      m_sft     = new_sft;
      unique case (kind)
         FUSE_SHIFT: m_sft = sft_sum[SW-1:0];
         FUSE_ADD:   m_add = add_sum[AW-1:0];
         FUSE_BOTH:  m_sft = new_sft;
         default:    can_merge = 1'b0;
      endcase
   end

endmodule

// File: rtl/cmf_hold_stage.sv
module cmf_hold_stage
   import cmf_pkg::*;
#(
   parameter int AW          = CMF_DEF_ADD_W,
   parameter int SW          = CMF_DEF_SFT_W,
   parameter int MAX_SHIFT   = CMF_DEF_MAX_SHIFT,
   parameter bit ADD_MERGE   = 1'b1,
   parameter bit SHIFT_MERGE = 1'b1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [AW-1:0] in_add,
   input  logic [SW-1:0] in_sft,
   input  logic          in_last,
   input  logic          space,
   output logic          push,
   output logic [AW-1:0] push_add,
   output logic [SW-1:0] push_sft,
   output logic          push_last
);

   logic          hv_q, hl_q;
   logic [AW-1:0] ha_q;
   logic [SW-1:0] hs_q;
   logic          hv_d, hl_d;
   logic [AW-1:0] ha_d;
   logic [SW-1:0] hs_d;

   logic          can_merge;
   logic [AW-1:0] m_add;
   logic [SW-1:0] m_sft;
   logic          flush_pend;
   logic          fire;

   cmf_merge_rule #(
      .AW(AW), .SW(SW), .MAX_SHIFT(MAX_SHIFT),
      .ADD_MERGE(ADD_MERGE), .SHIFT_MERGE(SHIFT_MERGE)
   ) u_rule (
      .held_add (ha_q),
      .held_sft (hs_q),
      .new_add  (in_add),
      .new_sft  (in_sft),
      .can_merge(can_merge),
      .m_add    (m_add),
      .m_sft    (m_sft)
   );

   assign flush_pend = hv_q && hl_q;
   assign in_ready   = space && !flush_pend;
   assign fire       = in_valid && in_ready;

   assign push_add  = ha_q;
   assign push_sft  = hs_q;
   assign push_last = hl_q;

   always_comb begin
      push = 1'b0;
      hv_d = hv_q;
      hl_d = hl_q;
      ha_d = ha_q;
      hs_d = hs_q;
      if (flush_pend) begin
         if (space) begin
            push = 1'b1;
            hv_d = 1'b0;
            hl_d = 1'b0;
         end
      end else if (fire) begin
         hv_d = 1'b1;
         hl_d = in_last;
         if (hv_q && can_merge) begin
            ha_d = m_add;
            hs_d = m_sft;
         end else begin
            push = hv_q;
            ha_d = in_add;
            hs_d = in_sft;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hv_q <= 1'b0;
         hl_q <= 1'b0;
         ha_q <= '0;
         hs_q <= '0;
      end else begin
         hv_q <= hv_d;
         hl_q <= hl_d;
         ha_q <= ha_d;
         hs_q <= hs_d;
      end
   end

   // R5
   flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last) |=> !in_ready);

endmodule

// File: rtl/cmf_queue.sv
module cmf_queue #(
   parameter int W     = 21,
   parameter int DEPTH = 16
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic         space,
   output logic         rd_valid,
   input  logic         rd_ready,
   output logic [W-1:0] rd_data
);

   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW   = $clog2(DEPTH + 1);
   localparam bit POW2 = (DEPTH > 1) && ((2 ** PW) == DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp_q, rp_q, wp_nx, rp_nx;
   logic [CW-1:0] cnt_q;
   logic          rd_en;

   assign space    = cnt_q < CW'(DEPTH);
   assign rd_valid = cnt_q != '0;
   assign rd_en    = rd_valid && rd_ready;
   assign rd_data  = mem[rp_q];

   generate
      if (POW2) begin : g_wrap_free
         assign wp_nx = wp_q + 1'b1;
         assign rp_nx = rp_q + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_nx = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
         assign rp_nx = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en) mem[wp_q] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (wr_en) wp_q <= wp_nx;
         if (rd_en) rp_q <= rp_nx;
         unique case ({wr_en, rd_en})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   // R7
   queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!space) |-> !wr_en);

   // R9
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

endmodule

// File: rtl/cm_update_fuser.sv
module cm_update_fuser
   import cmf_pkg::*;
#(
   parameter int AW          = CMF_DEF_ADD_W,
   parameter int SW          = CMF_DEF_SFT_W,
   parameter int MAX_SHIFT   = CMF_DEF_MAX_SHIFT,
   parameter int DEPTH       = CMF_DEF_DEPTH,
   parameter bit ADD_MERGE   = 1'b1,
   parameter bit SHIFT_MERGE = 1'b1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [AW-1:0] in_add,
   input  logic [SW-1:0] in_sft,
   input  logic          in_last,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [AW-1:0] out_add,
   output logic [SW-1:0] out_sft,
   output logic          out_last
);

   localparam int QW = AW + SW + 1;

   generate
      if (AW < 1 || SW < 1) begin : g_bad_width
         $error("cm_update_fuser: field widths must be positive");
      end
      if (MAX_SHIFT < 1 || MAX_SHIFT >= (2 ** SW)) begin : g_bad_shift
         $error("cm_update_fuser: MAX_SHIFT must fit in the shift field");
      end
      if (DEPTH < 1) begin : g_bad_depth
         $error("cm_update_fuser: DEPTH must be at least one");
      end
   endgenerate

   logic          space;
   logic          push;
   logic [AW-1:0] push_add;
   logic [SW-1:0] push_sft;
   logic          push_last;
   logic [QW-1:0] head;

   cmf_hold_stage #(
      .AW(AW), .SW(SW), .MAX_SHIFT(MAX_SHIFT),
      .ADD_MERGE(ADD_MERGE), .SHIFT_MERGE(SHIFT_MERGE)
   ) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_add   (in_add),
      .in_sft   (in_sft),
      .in_last  (in_last),
      .space    (space),
      .push     (push),
      .push_add (push_add),
      .push_sft (push_sft),
      .push_last(push_last)
   );

   cmf_queue #(.W(QW), .DEPTH(DEPTH)) u_queue (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (push),
      .wr_data ({push_last, push_add, push_sft}),
      .space   (space),
      .rd_valid(out_valid),
      .rd_ready(out_ready),
      .rd_data (head)
   );

   assign out_last = head[QW-1];
   assign out_add  = head[QW-2:SW];
   assign out_sft  = head[SW-1:0];

   // R1
   reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (in_ready && !out_valid));

endmodule

// File: tb/tb_cm_update_fuser.sv
module tb_cm_update_fuser;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 16;
   localparam int WATCHDOG   = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_add = '0;
   logic [3:0]  in_sft = '0;
   logic        in_last = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [15:0] out_add;
   logic [3:0]  out_sft;
   logic        out_last;

   always #(CLK_PERIOD/2) clk = ~clk;

   cm_update_fuser #(.DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready),
      .in_add(in_add), .in_sft(in_sft), .in_last(in_last),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_add(out_add), .out_sft(out_sft), .out_last(out_last)
   );

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   // behavioural reference state
   bit          mh_v, mh_l;
   int          mh_a, mh_s;
   logic [20:0] mq[$];
   logic [63:0] in_reg, out_reg;
   logic [63:0] blk_q[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      mh_v = 0; mh_l = 0; mh_a = 0; mh_s = 0;
      mq.delete(); blk_q.delete();
      in_reg = '0; out_reg = '0;
   endtask

   // one clock: drive at falling edge, compare, then step the model
   task automatic step(input bit v, input int a, input int s, input bit l,
                       input bit r, output bit fired);
      bit exp_ready, exp_ov, pop;
      int sz0;
      logic [20:0] hd;
      @(negedge clk);
      in_valid = v; in_add = 16'(a); in_sft = 4'(s); in_last = l; out_ready = r;
      #1;
      sz0       = mq.size();
      exp_ready = (sz0 < DEPTH) && !(mh_v && mh_l);
      exp_ov    = sz0 > 0;
      if (v) chk(in_ready == exp_ready, "R7", "in_ready", in_ready, exp_ready);
      else   chk(in_ready == exp_ready, "R9", "in_ready idle", in_ready, exp_ready);
      chk(out_valid == exp_ov, "R5", "out_valid", out_valid, exp_ov);
      if (exp_ov && out_valid) begin
         hd = mq[0];
         chk({out_last, out_add, out_sft} == hd, "R2 R3 R4", "out update",
             {out_last, out_add, out_sft}, hd);
         chk(out_sft <= 4'd15, "R6", "out shift", out_sft, 15);
      end
      fired = v && exp_ready;
      pop   = exp_ov && r;
      if (pop) begin
         hd = mq.pop_front();
         out_reg = (out_reg + 64'(hd[19:4])) << hd[3:0];
         if (hd[20]) begin
            if (blk_q.size() == 0) begin
               chk(1'b0, "R8", "block end without input end", 1, 0);
            end else begin
               logic [63:0] ref_v;
               ref_v = blk_q.pop_front();
               chk(out_reg[27:0] == ref_v[27:0], "R8", "code register", out_reg[27:0], ref_v[27:0]);
               chk(out_reg[63:28] == ref_v[63:28], "R8", "carries", out_reg[63:28], ref_v[63:28]);
            end
            out_reg = '0;
         end
      end
      if (fired) begin
         in_reg = (in_reg + 64'(a)) << s;
         if (l) begin
            blk_q.push_back(in_reg);
            in_reg = '0;
         end
      end
      if (mh_v && mh_l) begin
         if (sz0 < DEPTH) begin
            mq.push_back({1'b1, 16'(mh_a), 4'(mh_s)});
            mh_v = 0; mh_l = 0;
         end
      end else if (fired) begin
         if (mh_v && a == 0 && mh_s + s <= 15) begin
            mh_s = mh_s + s; mh_l = l;
         end else if (mh_v && mh_s == 0 && mh_a + a < 65536) begin
            mh_a = mh_a + a; mh_s = s; mh_l = l;
         end else begin
            if (mh_v) mq.push_back({mh_l, 16'(mh_a), 4'(mh_s)});
            mh_v = 1; mh_a = a; mh_s = s; mh_l = l;
         end
      end
      @(posedge clk);
   endtask

   task automatic send(input int a, input int s, input bit l);
      bit f;
      f = 0;
      while (!f) step(1, a, s, l, 1, f);
   endtask

   function automatic int pick_add();
      int k;
      k = $urandom_range(0, 9);
      if (k < 4) return 0;
      if (k < 6) return $urandom_range(1, 255);
      if (k < 8) return $urandom_range(0, 65535);
      return $urandom_range(65000, 65535);
   endfunction

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin : stimulus
      bit f;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
      chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      @(posedge clk);

      // directed boundaries: R2 shift sum 15 then 16, R3 addend sum 0xFFFF then 0x10000, R5 last
      send(100, 7, 0);
      send(0, 8, 0);
      send(0, 1, 0);
      send(5, 0, 0);
      send(16'hFFFA, 2, 0);
      send(7, 0, 0);
      send(16'hFFF9, 0, 0);
      send(0, 0, 1);
      repeat (6) step(0, 0, 0, 0, 1, f);

      // random phases with different output stall patterns (R7 fill, R8 equivalence)
      for (int ph = 0; ph < 4; ph++) begin
         for (int c = 0; c < 1500; c++) begin
            bit v, l, r;
            int s;
            v = $urandom_range(0, 3) != 0;
            l = $urandom_range(0, 29) == 0;
            s = ($urandom_range(0, 9) < 4) ? 0 : $urandom_range(0, 15);
            case (ph)
               0: r = 1'b1;
               1: r = $urandom_range(0, 1) == 1;
               2: r = $urandom_range(0, 9) == 0;
               default: r = $urandom_range(0, 3) != 0;
            endcase
            step(v, pick_add(), s, l, r, f);
         end
      end
      send(3, 1, 1);
      for (int c = 0; c < 3 * DEPTH + 8; c++) step(0, 0, 0, 0, 1, f);
      // R5: everything flushed, nothing pending
      chk(out_valid == 1'b0, "R5", "drained", out_valid, 0);
      chk(blk_q.size() == 0, "R8", "open blocks", blk_q.size(), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule